// File: doc/BRIEF.md
# Branch Metric Window Store

This block sits at the input of a sliding-window soft-output decoder for a rate-1/2 recursive systematic convolutional code. Each accepted input sample carries a systematic soft value, a parity soft value and an a-priori value. From these the block computes a single branch metric for the stage. It writes that metric into one of three window buffers. Each buffer is M stages deep, and consecutive windows of M samples go to the buffers in rotation.

On every accepted sample the block also reads back three stages from stored windows, one for each of three consumers. The forward recursion gets the window two back, in ascending order. The warm-up (dummy) backward recursion gets the previous window, in descending order. The real backward recursion with the LLR stage gets the window three back, in descending order. That last window occupies the buffer being overwritten in the same cycle.

A router turns each stored word into the four parent branch metrics. The two same-sign transitions come from the stored metric and its negation. The two mixed-sign transitions come from a stored copy of the parity value. The read streams advance only with accepted input samples, so a stalled input also stalls all three consumers.

Top module: `bm_store`

## Requirements
- R1: The (+1,+1) parent metric of a stage equals floor(a/2) + s + p, where s is the systematic value, p the parity value and a the a-priori value. All three are two's complement. The halving is an arithmetic shift right by one.
- R2: Each read-stream bus carries four signed fields of SW+3 bits. Bits [GW-1:0] hold the (+1,+1) metric. The next field holds (+1,-1) = floor(a/2) + s - p. The next holds (-1,+1), the negation of (+1,-1). The top field holds (-1,-1), the negation of (+1,+1).
- R3: The k-th group of M accepted samples after reset (window k, counted from 0) is stored in buffer k mod 3. A buffer is reused by window k+3 only after window k has been fully re-read by the real backward stream.
- R4: For accepted sample i (0..M-1) of window w with w >= 2, the forward stream returns stage i of window w-2.
- R5: For accepted sample i of window w with w >= 1, the dummy stream returns stage M-1-i of window w-1.
- R6: For accepted sample i of window w with w >= 3, the backward stream returns stage M-1-i of window w-3. It returns the old contents, even though window w writes into the same buffer during the same cycles.
- R7: Each stream's valid output is high in the cycle after an accepted sample whose window index meets that stream's minimum (2, 1 or 3). It is low in every other cycle. A valid backward stream implies a valid forward stream, and a valid forward stream implies a valid dummy stream.
- R8: An active-low asynchronous reset clears the window count, the stage index and the rotation. It drives all three valid outputs low. The first window after reset goes to buffer 0.
- R9: A cycle with in_valid low changes no state. The following cycle shows no valid output, and the sequence resumes unchanged on the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample accepted this cycle |
| in_sys | input | SW | Systematic soft value, signed |
| in_par | input | SW | Parity soft value, signed |
| in_apr | input | SW | A-priori value, signed |
| fwd_valid | output | 1 | Forward stream data valid |
| fwd_bm | output | 4*(SW+3) | Forward stream parent metrics |
| dmy_valid | output | 1 | Dummy backward stream data valid |
| dmy_bm | output | 4*(SW+3) | Dummy stream parent metrics |
| bwd_valid | output | 1 | Real backward stream data valid |
| bwd_bm | output | 4*(SW+3) | Backward stream parent metrics |

## Verification
Each of the three streams answers exactly one clock after the accepted sample that triggers its read, because the buffers have registered reads and the router is combinational. The bench therefore checks, at the falling edge after each sample, the outputs that belong to the previous sample. It maps that sample number to its window and stage, and from there to the logged source sample for each stream. An idle cycle is checked at the next falling edge for all-low valids. A reset in the middle of a window is followed by enough samples to show that the rotation and the stage index restarted.

// File: rtl/bm_store_pkg.sv
package bm_store_pkg;
   // Read stream identifiers; the value is also the buffer offset of the
   // stream relative to the buffer currently being written.
   typedef enum int unsigned {
      STREAM_BWD = 0,
      STREAM_FWD = 1,
      STREAM_DMY = 2
   } stream_e;

   localparam int NUM_BUF    = 3;
   localparam int NUM_STREAM = 3;
endpackage

// File: rtl/bm_calc.sv
module bm_calc #(
   parameter int SW = 8,
   localparam int MW = SW + 2
) (
   input  logic signed [SW-1:0] sys,
   input  logic signed [SW-1:0] par,
   input  logic signed [SW-1:0] apr,
   output logic signed [MW-1:0] metric
);
   logic signed [MW-1:0] apr_x, sys_x, par_x;

   always_comb begin
      apr_x  = {{2{apr[SW-1]}}, apr};
      sys_x  = {{2{sys[SW-1]}}, sys};
      par_x  = {{2{par[SW-1]}}, par};
      // channel reliability of 2 folds into a halved a-priori term
      metric = (apr_x >>> 1) + sys_x + par_x;
   end
endmodule

// File: rtl/bm_bank.sv
module bm_bank #(
   parameter int DW = 18,
   parameter int M  = 32,
   parameter int AW = 5
) (
   input  logic                clk,
   input  logic                we,
   input  logic [2:0]          wsel,
   input  logic [AW-1:0]       addr,
   input  logic [DW-1:0]       wdata,
   input  logic                re,
   output logic [2:0][DW-1:0]  rdata
);
   for (genvar j = 0; j < bm_store_pkg::NUM_BUF; j++) begin : g_buf
      logic [DW-1:0] mem [M];
      logic [DW-1:0] q;

      // registered read sees the old word when the same address is written
      always_ff @(posedge clk) begin
         if (we && wsel[j]) mem[addr] <= wdata;
         if (re)            q         <= mem[addr];
      end
      assign rdata[j] = q;
   end
endmodule

// File: rtl/bm_route.sv
module bm_route #(
   parameter int SW = 8,
   localparam int MW = SW + 2,
   localparam int GW = SW + 3,
   localparam int DW = MW + SW
) (
   input  logic [DW-1:0]   stored,
   output logic [4*GW-1:0] bus
);
   logic signed [GW-1:0] g_x, p_x, m_pp, m_pm, m_mp, m_mm;

   always_comb begin
      g_x  = {{(GW-MW){stored[DW-1]}}, stored[DW-1:SW]};
      p_x  = {{(GW-SW){stored[SW-1]}}, stored[SW-1:0]};
      m_pp = g_x;
      m_pm = g_x - (p_x <<< 1);
      m_mp = -m_pm;
      m_mm = -m_pp;
      bus  = {m_mm, m_mp, m_pm, m_pp};
   end
endmodule

// File: rtl/bm_store.sv
module bm_store
   import bm_store_pkg::*;
#(
   parameter int SW = 8,
   parameter int M  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic signed [SW-1:0]  in_sys,
   input  logic signed [SW-1:0]  in_par,
   input  logic signed [SW-1:0]  in_apr,
   output logic                  fwd_valid,
   output logic [4*(SW+3)-1:0]   fwd_bm,
   output logic                  dmy_valid,
   output logic [4*(SW+3)-1:0]   dmy_bm,
   output logic                  bwd_valid,
   output logic [4*(SW+3)-1:0]   bwd_bm
);
   localparam int AW = (M > 1) ? $clog2(M) : 1;
   localparam int MW = SW + 2;
   localparam int GW = SW + 3;
   localparam int DW = MW + SW;
   localparam int BW = 4 * GW;

   if (M < 2) begin : g_bad_depth
      $error("bm_store: window depth M must be at least 2");
   end
   if (SW < 2) begin : g_bad_width
      $error("bm_store: soft value width SW must be at least 2");
   end

   logic [AW-1:0]           idx, waddr;
   logic                    dir, last;
   logic [2:0]              sel, sel_q;
   logic [1:0]              fill;
   logic signed [MW-1:0]    metric;
   logic [2:0][DW-1:0]      rd;
   logic [2:0][BW-1:0]      sbus;

   bm_calc #(.SW(SW)) u_calc (
      .sys    (in_sys),
      .par    (in_par),
      .apr    (in_apr),
      .metric (metric)
   );

   // One address serves the write and all three reads: each window is
   // stored in the opposite direction to the window three before it.
   assign last  = (idx == AW'(M - 1));
   assign waddr = dir ? (AW'(M - 1) - idx) : idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         dir  <= 1'b0;
         sel  <= 3'b001;
         fill <= 2'd0;
      end else if (in_valid) begin
         if (last) begin
            idx <= '0;
            dir <= ~dir;
            sel <= {sel[1:0], sel[2]};
            if (fill != 2'd3) fill <= fill + 2'd1;
         end else begin
            idx <= idx + AW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         dmy_valid <= 1'b0;
         bwd_valid <= 1'b0;
         sel_q     <= 3'b001;
      end else begin
         fwd_valid <= in_valid && (fill >= 2'd2);
         dmy_valid <= in_valid && (fill >= 2'd1);
         bwd_valid <= in_valid && (fill == 2'd3);
         if (in_valid) sel_q <= sel;
      end
   end

   bm_bank #(.DW(DW), .M(M), .AW(AW)) u_bank (
      .clk   (clk),
      .we    (in_valid),
      .wsel  (sel),
      .addr  (waddr),
      .wdata ({metric, in_par}),
      .re    (in_valid),
      .rdata (rd)
   );

   for (genvar s = 0; s < NUM_STREAM; s++) begin : g_strm
      logic [DW-1:0] pick;
      logic [BW-1:0] bus;

      always_comb begin
         pick = '0;
         for (int j = 0; j < NUM_BUF; j++) begin
            if (sel_q[j]) pick = pick | rd[(j + s) % NUM_BUF];
         end
      end

      bm_route #(.SW(SW)) u_route (
         .stored (pick),
         .bus    (bus)
      );
      assign sbus[s] = bus;
   end

   assign fwd_bm = sbus[STREAM_FWD];
   assign dmy_bm = sbus[STREAM_DMY];
   assign bwd_bm = sbus[STREAM_BWD];
endmodule

// File: rtl/bm_store_chk.sv
module bm_store_chk #(
   parameter int M  = 32,
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [AW-1:0] idx,
   input logic [2:0]    sel,
   input logic          fwd_valid,
   input logic          dmy_valid,
   input logic          bwd_valid
);
   assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sel));

   assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && idx == AW'(M - 1)) |=> (sel == {$past(sel[1:0]), $past(sel[2])}));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(sel) && $stable(idx)));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!fwd_valid && !dmy_valid && !bwd_valid));

   assert_order_bwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bwd_valid |-> fwd_valid);

   assert_order_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> dmy_valid);
endmodule

bind bm_store bm_store_chk #(.M(M), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .idx       (idx),
   .sel       (sel),
   .fwd_valid (fwd_valid),
   .dmy_valid (dmy_valid),
   .bwd_valid (bwd_valid)
);

// File: tb/bm_store_test.sv
module bm_store_test;
   localparam int PERIOD = 10;
   localparam int SW = 8;
   localparam int M  = 4;
   localparam int GW = SW + 3;
   localparam int BW = 4 * GW;
   localparam int NT = 8;
   // sys, par, apr, expected (+1,+1), expected (+1,-1)
   localparam int TAB [NT][5] = '{
      '{   0,    0,    0,    0,    0},
      '{ 127,  127,  127,  317,   63},
      '{-128, -128, -128, -320,  -64},
      '{ 127, -128,  127,   62,  318},
      '{-128,  127, -128,  -65, -319},
      '{  10,   -3,    5,    9,   15},
      '{  -7,    4,   -1,   -4,  -12},
      '{   1,    1,   -3,    0,   -2}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [SW-1:0] in_sys = '0, in_par = '0, in_apr = '0;
   logic fwd_valid, dmy_valid, bwd_valid;
   logic [BW-1:0] fwd_bm, dmy_bm, bwd_bm;

   int total = 0, bad = 0;
   int ly1 [256], ly2 [256], lap [256];
   int n = 0, prev_n = 0;
   bit prev_acc = 0, first_run = 1;

   always #(PERIOD/2) clk = ~clk;

   bm_store #(.SW(SW), .M(M)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_sys(in_sys), .in_par(in_par), .in_apr(in_apr),
      .fwd_valid(fwd_valid), .fwd_bm(fwd_bm),
      .dmy_valid(dmy_valid), .dmy_bm(dmy_bm),
      .bwd_valid(bwd_valid), .bwd_bm(bwd_bm)
   );

   function automatic logic [BW-1:0] mk(int pp, int pm);
      return {GW'(-pp), GW'(-pm), GW'(pm), GW'(pp)};
   endfunction

   // R1, R2: reference parent metrics for logged sample k
   function automatic logic [BW-1:0] expv(int k);
      int h;
      if (first_run && k < NT) return mk(TAB[k][3], TAB[k][4]);
      h = lap[k] >>> 1;
      return mk(h + ly1[k] + ly2[k], h + ly1[k] - ly2[k]);
   endfunction

   task automatic chk_bus(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_bit(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   // outputs due one cycle after the previous step
   task automatic settle();
      int w, i;
      if (prev_acc) begin
         w = prev_n / M;
         i = prev_n % M;
         chk_bit("R7 fwd valid", fwd_valid, w >= 2);
         chk_bit("R7 dmy valid", dmy_valid, w >= 1);
         chk_bit("R7 bwd valid", bwd_valid, w >= 3);
         if (w >= 2) chk_bus("R4 R1 R2 fwd metrics", fwd_bm, expv(M*(w-2) + i));
         if (w >= 1) chk_bus("R5 dmy metrics", dmy_bm, expv(M*(w-1) + M-1-i));
         if (w >= 3) chk_bus("R3 R6 bwd metrics", bwd_bm, expv(M*(w-3) + M-1-i));
      end else begin
         chk_bit("R9 idle fwd", fwd_valid, 1'b0);
         chk_bit("R9 idle dmy", dmy_valid, 1'b0);
         chk_bit("R9 idle bwd", bwd_valid, 1'b0);
      end
   endtask

   task automatic step(bit v, int a, int b, int c);
      @(negedge clk);
      settle();
      in_valid = v;
      in_sys = SW'(a);
      in_par = SW'(b);
      in_apr = SW'(c);
      prev_acc = v;
      if (v) begin
         ly1[n] = a; ly2[n] = b; lap[n] = c;
         prev_n = n;
         n++;
      end
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(PERIOD * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk_bit("R8 reset fwd", fwd_valid, 1'b0);
      chk_bit("R8 reset dmy", dmy_valid, 1'b0);
      chk_bit("R8 reset bwd", bwd_valid, 1'b0);
      rst_n = 1'b1;

      // table vectors first, then generated values; idle gaps for R9
      for (int k = 0; k < NT + 5*M + 1; k++) begin
         if (k < NT) step(1, TAB[k][0], TAB[k][1], TAB[k][2]);
         else step(1, ((k*37 + 11) % 256) - 128, ((k*91 + 5) % 256) - 128,
                   ((k*53 + 17) % 256) - 128);
         if (k % 5 == 4) step(0, 99, -99, 50);
      end
      step(0, 0, 0, 0);

      // R8: reset in the middle of a window
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_bit("R8 mid reset fwd", fwd_valid, 1'b0);
      chk_bit("R8 mid reset dmy", dmy_valid, 1'b0);
      chk_bit("R8 mid reset bwd", bwd_valid, 1'b0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      prev_acc = 0;
      first_run = 0;
      for (int k = 0; k < 4*M + 2; k++) begin
         step(1, ((k*29 + 3) % 256) - 128, ((k*67 + 40) % 256) - 128,
              ((k*13 + 90) % 256) - 128);
         if (k == M + 1) step(0, -5, 5, 7);
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      summary();
      $finish;
   end
endmodule